// File: doc/BRIEF.md
# TDM PCM Voice Serial Port

This block carries 8-bit companded voice samples for up to two channels over a 32-slot time-division PCM link that runs at 2.048 MHz. Each channel owns one timeslot. Its transmit byte goes out on the serial output, most significant bit first. Its receive byte is assembled from the serial input. A frame has 256 bit periods and one sample per channel, so there are 8,000 frames per second and each channel carries 64 kbps.

The port runs in one of two modes. As clock master it divides the fast system clock by `DIV` to make the bit clock and drives a frame sync. With the default of 48, a 98.304 MHz system clock gives 2.048 MHz. As slave it follows a bit clock and frame sync from another device. Both are brought into the system clock domain through synchronizers, and their edges are detected there. The parallel side has a load strobe per channel for transmit bytes and a one-cycle valid strobe per channel for received bytes. The companding-law select is passed through as a registered configuration output. The block does no companding itself.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sdo`, `sdo_oe`, `bclk_o`, `fsync_o`, `rx_valid` and `law_out` are all 0.
- R2: In master mode, `bclk_o` has a period of exactly `DIV` system clocks and stays high for `DIV/2` of them.
- R3: In master mode, `fsync_o` rises together with `bclk_o` at the start of bit 0 of each frame and stays high for one bit period. It repeats every 256 bit periods.
- R4: In slave mode, `bclk_o` and `fsync_o` stay low. The port times itself from the synchronized `ext_bclk`. A rising edge of `ext_bclk` seen while `ext_fsync` is high starts bit 0 of a frame.
- R5: The bits of slot s are frame bits 8*s to 8*s+7. During a channel's slot, `sdo` carries that channel's transmit byte MSB first and changes only on bit-clock rising edges, and `sdo_oe` is 1. In every other bit `sdo_oe` is 0 and `sdo` is 0.
- R6: The transmit byte is taken at the start of each frame. A byte loaded with `tx_load` during frame k is sent in frame k+1. If several loads happen in one frame, the last one is sent.
- R7: When no byte is loaded during a frame, the next frame repeats the previous byte. Before any load after reset, the byte is 8'hFF.
- R8: `sdi` is sampled on bit-clock falling edges during a channel's slot, MSB first. After the eighth bit, `rx_data` for that channel holds the byte and `rx_valid` pulses for exactly one system clock.
- R9: The two channels work independently in any slots from 0 to 31, including slot 0 (which shares its first edge with the frame start) and slot 31 (the last bits of the frame). Channel c uses `slot_sel[5c+4:5c]`, `tx_data[8c+7:8c]` and `rx_data[8c+7:8c]`.
- R10: `law_out` equals `law_sel` delayed by one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (98.304 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate bit clock and frame sync; 0: follow external ones |
| law_sel | input | 1 | Companding-law select |
| law_out | output | 1 | Registered copy of `law_sel` |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fsync | input | 1 | External frame sync (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | High while the port drives an owned slot |
| slot_sel | input | NCH*5 | Timeslot number per channel |
| tx_data | input | NCH*8 | Transmit byte per channel |
| tx_load | input | NCH | Load strobe per channel for `tx_data` |
| rx_data | output | NCH*8 | Last received byte per channel |
| rx_valid | output | NCH | One-cycle strobe per channel when `rx_data` updates |

## Verification
The bench targets the frame boundary. Slot 0 must send the byte latched on that same edge; a design that read the old shadow register would send the previous frame's byte there. Slot 31 ends exactly where the next frame begins, so an off-by-one in the bit counter would lose or shift its last bit. Frames with no load, one load and two loads show whether a design drops the repeated byte, sends 0 after reset instead of 8'hFF, or keeps the first of two loads. Running once in each clock mode exposes a design that samples receive bits on the wrong edge, or that misaligns the synchronized frame sync by a bit.

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port #(
  parameter int DIV = 48,
  parameter int NCH = 2,
  parameter int SW  = 5,
  parameter int W   = 8
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master,
  input  logic           law_sel,
  output logic           law_out,
  input  logic           ext_bclk,
  input  logic           ext_fsync,
  output logic           bclk_o,
  output logic           fsync_o,
  input  logic           sdi,
  output logic           sdo,
  output logic           sdo_oe,
  input  logic [NCH*SW-1:0] slot_sel,
  input  logic [NCH*W-1:0]  tx_data,
  input  logic [NCH-1:0]    tx_load,
  output logic [NCH*W-1:0]  rx_data,
  output logic [NCH-1:0]    rx_valid
);
  localparam int BPS = $clog2(W);
  localparam int CW  = SW + BPS;
  localparam int DW  = $clog2(DIV);

  logic [DW-1:0] divcnt;
  logic [2:0]    bs;
  logic [1:0]    fs;
  logic [CW-1:0] bitcnt;
  logic          bclk_q, fsync_q, sbit;
  logic [NCH-1:0] hit, nhit, tbit;

  wire rise = master ? (divcnt == '0) : (bs[1] & ~bs[2]);
  wire fall = master ? (divcnt == DW'(DIV/2)) : (~bs[1] & bs[2]);
  wire [CW-1:0] nxt = (!master && fs[1]) ? '0 : bitcnt + CW'(1);
  wire frame_start = rise && (nxt == '0);

  assign bclk_o  = bclk_q & master;
  assign fsync_o = fsync_q & master;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [SW-1:0] sl = slot_sel[c*SW +: SW];
    logic [W-1:0] pend, shad, rsh, rxq;
    logic         vq;
    wire  [W-1:0] cur = (nxt == '0) ? pend : shad;

    assign hit[c]  = bitcnt[CW-1:BPS] == sl;
    assign nhit[c] = nxt[CW-1:BPS] == sl;
    assign tbit[c] = cur[BPS'(W-1) - nxt[BPS-1:0]];
    assign rx_data[c*W +: W] = rxq;
    assign rx_valid[c] = vq;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend <= '1; shad <= '1; rsh <= '0; rxq <= '0; vq <= 1'b0;
      end else begin
        vq <= 1'b0;
        if (tx_load[c]) pend <= tx_data[c*W +: W];
        if (frame_start) shad <= pend;
        if (fall && hit[c]) begin
          rsh <= {rsh[W-2:0], sdi};
          if (bitcnt[BPS-1:0] == BPS'(W-1)) begin
            rxq <= {rsh[W-2:0], sdi};
            vq  <= 1'b1;
          end
        end
      end
  end

  always_comb begin
    sbit = 1'b0;
    for (int c = NCH-1; c >= 0; c--)
      if (nhit[c]) sbit = tbit[c];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      divcnt <= '0; bs <= '0; fs <= '0; bitcnt <= '1;
      bclk_q <= 1'b0; fsync_q <= 1'b0; sdo <= 1'b0; sdo_oe <= 1'b0; law_out <= 1'b0;
    end else begin
      law_out <= law_sel;
      bs <= {bs[1:0], ext_bclk};
      fs <= {fs[0], ext_fsync};
      divcnt <= (divcnt == DW'(DIV-1)) ? '0 : divcnt + DW'(1);
      if (rise) begin
        bitcnt  <= nxt;
        sdo     <= sbit;
        sdo_oe  <= |nhit;
        bclk_q  <= master;
        fsync_q <= master && (nxt == '0);
      end
      if (fall) bclk_q <= 1'b0;
    end
endmodule

module pcm_tdm_port_chk #(
  parameter int DIV = 48,
  parameter int NCH = 2
)(
  input logic           clk,
  input logic           rst_n,
  input logic           master,
  input logic           law_sel,
  input logic           law_out,
  input logic           bclk_o,
  input logic           fsync_o,
  input logic           sdo,
  input logic           sdo_oe,
  input logic [NCH-1:0] rx_valid
);
  int unsigned per;
  logic bprev, seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per <= 0; bprev <= 1'b0; seen <= 1'b0;
    end else begin
      bprev <= bclk_o;
      if (bclk_o && !bprev) begin per <= 1; seen <= 1'b1; end
      else per <= per + 1;
    end

  p_bclk_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master && bclk_o && !bprev && seen) |-> per == DIV);
  p_fsync_with_bclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> $rose(bclk_o));
  p_slave_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!bclk_o && !fsync_o));
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  p_sdo_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$rose(bclk_o)) |-> $stable(sdo));
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> !(|rx_valid));
  p_law_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> law_out == $past(law_sel));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.DIV(DIV), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .law_sel(law_sel), .law_out(law_out),
  .bclk_o(bclk_o), .fsync_o(fsync_o), .sdo(sdo), .sdo_oe(sdo_oe), .rx_valid(rx_valid)
);

// File: tb/test_pcm_tdm_port.sv
`timescale 1ns/1ps
module test_pcm_tdm_port;
  localparam int DIV = 8, NCH = 2, W = 8, SW = 5, HS = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, master = 1'b1, law_sel = 1'b0;
  logic ext_bclk = 1'b0, ext_fsync = 1'b0, sdi = 1'b0;
  logic [NCH*SW-1:0] slot_sel = '0;
  logic [NCH*W-1:0]  tx_data = '0;
  logic [NCH-1:0]    tx_load = '0;
  wire law_out, bclk_o, fsync_o, sdo, sdo_oe;
  wire [NCH*W-1:0] rx_data;
  wire [NCH-1:0]   rx_valid;

  pcm_tdm_port #(.DIV(DIV), .NCH(NCH), .SW(SW), .W(W)) i_pcm_tdm_port (
    .clk(clk), .rst_n(rst_n), .master(master), .law_sel(law_sel), .law_out(law_out),
    .ext_bclk(ext_bclk), .ext_fsync(ext_fsync), .bclk_o(bclk_o), .fsync_o(fsync_o),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .slot_sel(slot_sel),
    .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data), .rx_valid(rx_valid));

  int checks = 0, errors = 0, phase = 0;
  bit run = 0, active = 0, rx_mon = 0, gen_on = 0;
  int idx = 0, fno = -1;
  logic [W-1:0] rx_cur [NCH];
  logic [W-1:0] cap [NCH];
  logic [W-1:0] exp_tx [NCH][$];
  logic [W-1:0] exp_rx [NCH][$];
  event frame_ev;

  wire lclk = master ? bclk_o : ext_bclk;
  wire lfs  = master ? fsync_o : ext_fsync;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(int c);
    return int'(slot_sel[c*SW +: SW]);
  endfunction
  function automatic logic [W-1:0] rx_pat(int f, int c);
    return 8'((32'hA5 ^ (f*29 + c*53 + phase*7)) & 32'hFF);
  endfunction
  function automatic logic [W-1:0] tx_pat(int f, int c, int k);
    return 8'((32'h5A ^ (f*37 + c*91 + k*13 + phase*5)) & 32'hFF);
  endfunction

  // serial model: far-end device driving sdi and capturing sdo
  always @(posedge lclk) begin
    #1;
    if (run) begin
      if (lfs) begin idx = 0; fno++; active = 1; ->frame_ev; end
      else idx++;
      sdi = 1'b0;
      if (active && idx < 256)
        for (int c = 0; c < NCH; c++)
          if (idx / 8 == slot_of(c)) begin
            if (idx % 8 == 0) begin
              rx_cur[c] = rx_pat(fno, c);
              exp_rx[c].push_back(rx_cur[c]);
            end
            sdi = rx_cur[c][7 - idx % 8];
          end
    end
  end

  always @(negedge lclk) begin
    #1;
    if (active) begin
      bit any;
      any = 0;
      for (int c = 0; c < NCH; c++) if (idx / 8 == slot_of(c)) any = 1;
      chk(sdo_oe == any, "R5", "sdo_oe", int'(sdo_oe), int'(any));
      if (!any) chk(sdo == 1'b0, "R5", "idle sdo", int'(sdo), 0);
      if (!master) chk(!bclk_o && !fsync_o, "R4", "slave outputs", int'({bclk_o, fsync_o}), 0);
      for (int c = 0; c < NCH; c++)
        if (idx / 8 == slot_of(c)) begin
          cap[c] = {cap[c][W-2:0], sdo};
          if (idx % 8 == 7) begin
            logic [W-1:0] e;
            e = (exp_tx[c].size() > 0) ? exp_tx[c].pop_front() : 8'hxx;
            chk(cap[c] === e, "R5 R6 R7 R9", $sformatf("tx ch%0d frame %0d", c, fno), int'(cap[c]), int'(e));
          end
        end
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (rst_n && rx_mon)
      for (int c = 0; c < NCH; c++)
        if (rx_valid[c]) begin
          logic [W-1:0] e;
          e = (exp_rx[c].size() > 0) ? exp_rx[c].pop_front() : 8'hxx;
          chk(rx_data[c*W +: W] === e, "R8 R9", $sformatf("rx ch%0d", c), int'(rx_data[c*W +: W]), int'(e));
        end
  end

  // slave-mode external link generator
  always begin
    wait (gen_on);
    for (int g = 0; gen_on; g++) begin
      ext_bclk = 1'b1;
      repeat (HS) @(negedge clk);
      ext_bclk = 1'b0;
      ext_fsync = ((g + 1) % 256 == 0);
      repeat (HS) @(negedge clk);
    end
  end

  // driver: decides the loads of each frame and predicts the next frame's byte
  task automatic run_frames(int n);
    logic [W-1:0] last [NCH];
    for (int c = 0; c < NCH; c++) last[c] = 8'hFF;
    repeat (n) begin
      @(frame_ev);
      repeat (20) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        int mode;
        mode = (fno + c) % 3;
        for (int k = 0; k < mode; k++) begin
          tx_data[c*W +: W] = tx_pat(fno, c, k);
          tx_load[c] = 1'b1;
          @(negedge clk);
          tx_load[c] = 1'b0;
          last[c] = tx_pat(fno, c, k);
        end
        exp_tx[c].push_back(last[c]);
      end
    end
  endtask

  task automatic drain();
    @(frame_ev);
    wait (idx == 255);
    @(negedge lclk);
    #2;
    run = 0; active = 0;
    repeat (4*HS + 10) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(exp_tx[c].size() == 0, "R6", "tx frames left", exp_tx[c].size(), 0);
      chk(exp_rx[c].size() == 0, "R8", "rx bytes left", exp_rx[c].size(), 0);
    end
    rx_mon = 0;
  endtask

  task automatic meas_master();
    realtime t0, t1, t2, f0, f1, f2;
    @(posedge bclk_o); t0 = $realtime;
    @(negedge bclk_o); t1 = $realtime;
    @(posedge bclk_o); t2 = $realtime;
    chk(t1 - t0 == DIV/2*8, "R2", "bclk high ns", int'(t1 - t0), DIV/2*8);
    chk(t2 - t0 == DIV*8, "R2", "bclk period ns", int'(t2 - t0), DIV*8);
    @(posedge fsync_o); f0 = $realtime;
    chk(bclk_o == 1'b1, "R3", "bclk at fsync rise", int'(bclk_o), 1);
    @(negedge fsync_o); f1 = $realtime;
    @(posedge fsync_o); f2 = $realtime;
    chk(f1 - f0 == DIV*8, "R3", "fsync width ns", int'(f1 - f0), DIV*8);
    chk(f2 - f0 == 256*DIV*8, "R3", "frame period ns", int'(f2 - f0), 256*DIV*8);
  endtask

  task automatic reset_checks();
    chk({sdo, sdo_oe, bclk_o, fsync_o, law_out} == 5'b0, "R1", "outputs in reset",
        int'({sdo, sdo_oe, bclk_o, fsync_o, law_out}), 0);
    chk(rx_valid == '0, "R1", "rx_valid in reset", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // phase 1: master, slots 3 and 17
    phase = 1;
    slot_sel = {5'd17, 5'd3};
    for (int c = 0; c < NCH; c++) exp_tx[c].push_back(8'hFF);
    repeat (5) @(negedge clk);
    reset_checks();
    run = 1; rx_mon = 1;
    rst_n = 1'b1;
    fork
      run_frames(5);
      meas_master();
    join
    drain();
    @(negedge clk) law_sel = 1'b1;
    @(negedge clk) chk(law_out == 1'b1, "R10", "law_out high", int'(law_out), 1);
    law_sel = 1'b0;
    @(negedge clk) chk(law_out == 1'b0, "R10", "law_out low", int'(law_out), 0);

    // phase 2: slave, slots 0 and 31
    phase = 2;
    rst_n = 1'b0;
    master = 1'b0;
    slot_sel = {5'd31, 5'd0};
    for (int c = 0; c < NCH; c++) begin
      exp_tx[c].delete();
      exp_rx[c].delete();
      exp_tx[c].push_back(8'hFF);
    end
    fno = -1;
    repeat (5) @(negedge clk);
    reset_checks();
    run = 1; rx_mon = 1;
    rst_n = 1'b1;
    @(negedge clk);
    chk({sdo_oe, rx_valid} == '0, "R1", "first cycle after reset", int'({sdo_oe, rx_valid}), 0);
    fork
      run_frames(5);
      begin
        repeat (3) @(negedge clk);
        ext_fsync = 1'b1;
        gen_on = 1;
      end
    join
    drain();
    gen_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule